// File: doc/BRIEF.md
# Paced Serial Transmitter

This block sends characters on an asynchronous serial line. It has two modes. In buffered mode, a single holding slot takes one character at a time from the write port. The slot hands the character to the shift register as soon as the shift register is idle. In FIFO mode, the holding slot is bypassed. The shift register pulls characters straight from a small queue. After each character it leaves the line idle for a programmable number of bit periods before it takes the next one. This gives the receiver paced flow without any hardware handshake lines.

The bit rate is set outside the block: a one-cycle `bit_tick` pulse marks every bit boundary. The block reports three status conditions:
- `tx_ready`: the block can take another character.
- `tx_empty`: no character is held anywhere in the block.
- `fifo_ovf`: a write reached a full queue.

It raises an interrupt request when it is ready and the interrupt is enabled. A software-reset input clears all pending work and returns the line to idle.

Top module: `uart_tx_paced`

## Requirements
- R1: After system reset, and in the cycle after `sw_rst` was high, `txd`=1, `tx_ready`=1, `tx_empty`=1, `fifo_empty`=1, `fifo_full`=0 and `fifo_ovf`=0.
- R2: Each character goes out as one low start bit, then 8 data bits with the least significant bit first, then one high stop bit. Every bit boundary after the start bit falls on a `bit_tick`.
- R3: In buffered mode (`fifo_mode`=0), a write while `tx_ready`=1 fills the holding slot and drives `tx_ready` low. The slot moves to an idle shift register on the next clock, and `tx_ready` returns high at that moment. Two buffered characters follow each other with zero idle bit periods between the stop bit and the next start bit.
- R4: In buffered mode, a write while `tx_ready`=0 is ignored, and the held character is not replaced.
- R5: `tx_irq` is high exactly when `tx_ready`=1 and `tx_int_en`=1.
- R6: `tx_empty` is high only when the holding slot, the queue and the shift register all hold no character.
- R7: In FIFO mode (`fifo_mode`=1), writes go to the queue and the holding slot is not used. In this mode `tx_ready` is the inverse of `fifo_full`.
- R8: In FIFO mode, after the stop bit the line stays high for `gap_len` bit periods before the next start bit. If `gap_len`=0 there is no gap. The next character is not loaded until the stop bit is complete.
- R9: The queue holds 4 characters and drives `fifo_full` and `fifo_empty`. A write to a full queue is dropped and sets `fifo_ovf`, which stays set until a reset.
- R10: A queue write in the same cycle the shift register takes a character from the queue stores the written character.
- R11: `sw_rst` clears the shift register, the queue, the holding slot, any gap in progress and `fifo_ovf`. Writes made while `sw_rst` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| sw_rst | input | 1 | Software reset, active high |
| fifo_mode | input | 1 | 1 = queue with gap, 0 = single holding slot |
| tx_int_en | input | 1 | Transmit interrupt enable |
| gap_len | input | GAP_W | Idle bit periods between characters in FIFO mode |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| tx_ready | output | 1 | Block can take a character |
| tx_empty | output | 1 | No character held anywhere |
| tx_irq | output | 1 | Transmit interrupt request |
| fifo_full | output | 1 | Queue holds 4 characters |
| fifo_empty | output | 1 | Queue holds none |
| fifo_ovf | output | 1 | Sticky: a write hit a full queue |

## Verification
The queue can accept a write in the same clock edge in which the idle shift register pops its oldest entry. The first two back-to-back FIFO writes produce exactly this case. The bench then keeps writing one character per cycle and judges the result by when `fifo_full` rises. It must stay low before the fifth write and be high before the sixth, and only the sixth write may set `fifo_ovf`. The decoded serial stream must then carry the first five characters in order.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;
    localparam int DEF_FIFO_DEPTH = 4;
    localparam int DEF_GAP_W = 8;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_START,
        SH_DATA,
        SH_STOP,
        SH_GAP
    } sh_state_e;

    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } char_slot_t;

    // Line level for a given shifter state
    function automatic logic line_level(sh_state_e st, logic lsb);
        case (st)
            SH_START: return 1'b0;
            SH_DATA:  return lsb;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic logic frame_busy(sh_state_e st);
        return (st == SH_START) || (st == SH_DATA) || (st == SH_STOP);
    endfunction

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              take,
    output char_slot_t        slot
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slot <= '0;
        end else if (take) begin
            slot.valid <= 1'b0;
        end else if (wr_en && !slot.valid) begin
            slot.valid <= 1'b1;
            slot.data  <= wr_data;
        end
    end

endmodule

// File: rtl/tx_fifo.sv
module tx_fifo
    import uart_tx_pkg::*;
#(
    parameter int DEPTH = DEF_FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              push,
    input  logic [CHAR_W-1:0] push_data,
    input  logic              pop,
    output char_slot_t        head,
    output logic              full,
    output logic              empty,
    output logic              ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_idx;
    logic [AW-1:0]     rd_idx;
    logic [CW-1:0]     count;
    logic              push_ok;
    logic              pop_ok;

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    assign head.valid = !empty;
    assign head.data  = mem[rd_idx];

    function automatic logic [AW-1:0] next_idx(logic [AW-1:0] idx);
        return (idx == LAST_IDX) ? '0 : idx + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_idx <= '0;
            rd_idx <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) begin
                wr_idx <= next_idx(wr_idx);
            end
            if (pop_ok) begin
                rd_idx <= next_idx(rd_idx);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) begin
                ovf <= 1'b1;
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (push_ok && (wr_idx == AW'(g))) begin
                    mem[g] <= push_data;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int GAP_W = DEF_GAP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              bit_tick,
    input  logic              gap_en,
    input  logic [GAP_W-1:0]  gap_len,
    input  char_slot_t        src,
    output logic              ld_fire,
    output logic              busy,
    output logic              txd
);

    localparam int BIT_CW = $clog2(CHAR_W);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(CHAR_W - 1);
    localparam logic [GAP_W-1:0]  GAP_ONE  = GAP_W'(1);

    sh_state_e         st;
    logic [CHAR_W-1:0] sh;
    logic [BIT_CW-1:0] bit_cnt;
    logic [GAP_W-1:0]  gap_cnt;

    assign ld_fire = (st == SH_IDLE) && src.valid && !clr;
    assign busy    = frame_busy(st);
    assign txd     = line_level(st, sh[0]);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st      <= SH_IDLE;
            sh      <= '0;
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            case (st)
                SH_IDLE: begin
                    if (ld_fire) begin
                        st      <= SH_START;
                        sh      <= src.data;
                        bit_cnt <= '0;
                    end
                end
                SH_START: begin
                    if (bit_tick) begin
                        st <= SH_DATA;
                    end
                end
                SH_DATA: begin
                    if (bit_tick) begin
                        sh <= sh >> 1;
                        if (bit_cnt == LAST_BIT) begin
                            st <= SH_STOP;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                SH_STOP: begin
                    if (bit_tick) begin
                        if (gap_en && (gap_len != '0)) begin
                            st      <= SH_GAP;
                            gap_cnt <= gap_len;
                        end else begin
                            st <= SH_IDLE;
                        end
                    end
                end
                SH_GAP: begin
                    if (bit_tick) begin
                        if (gap_cnt == GAP_ONE) begin
                            st <= SH_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt - 1'b1;
                        end
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_paced.sv
module uart_tx_paced
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = DEF_FIFO_DEPTH,
    parameter int GAP_W      = DEF_GAP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              fifo_mode,
    input  logic              tx_int_en,
    input  logic [GAP_W-1:0]  gap_len,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              tx_irq,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              fifo_ovf
);

    char_slot_t hold_slot;
    char_slot_t fifo_head;
    char_slot_t sh_src;
    logic       hold_wr;
    logic       fifo_push;
    logic       ld_fire;
    logic       sh_busy;

    assign hold_wr   = wr_en && !fifo_mode && !sw_rst;
    assign fifo_push = wr_en && fifo_mode && !sw_rst;
    assign sh_src    = fifo_mode ? fifo_head : hold_slot;

    tx_hold_buf i_hold (
        .clk     (clk),
        .rst     (rst),
        .clr     (sw_rst),
        .wr_en   (hold_wr),
        .wr_data (wr_data),
        .take    (ld_fire && !fifo_mode),
        .slot    (hold_slot)
    );

    tx_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) i_fifo (
        .clk       (clk),
        .rst       (rst),
        .clr       (sw_rst),
        .push      (fifo_push),
        .push_data (wr_data),
        .pop       (ld_fire && fifo_mode),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .ovf       (fifo_ovf)
    );

    tx_shifter #(
        .GAP_W (GAP_W)
    ) i_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (sw_rst),
        .bit_tick (bit_tick),
        .gap_en   (fifo_mode),
        .gap_len  (gap_len),
        .src      (sh_src),
        .ld_fire  (ld_fire),
        .busy     (sh_busy),
        .txd      (txd)
    );

    assign tx_ready = fifo_mode ? !fifo_full : !hold_slot.valid;
    assign tx_empty = !hold_slot.valid && fifo_empty && !sh_busy;
    assign tx_irq   = tx_ready && tx_int_en;

endmodule

// File: rtl/uart_tx_paced_chk.sv
module uart_tx_paced_chk (
    input logic clk,
    input logic rst,
    input logic sw_rst,
    input logic tx_int_en,
    input logic bit_tick,
    input logic wr_en,
    input logic ld_fire,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty,
    input logic tx_irq,
    input logic fifo_full,
    input logic fifo_empty,
    input logic fifo_ovf
);

    a_r1_swrst_idle: assert property (@(posedge clk) disable iff (rst)
        $past(sw_rst) |-> (txd && tx_ready && tx_empty && fifo_empty && !fifo_ovf));

    a_r2_line_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(bit_tick || ld_fire || sw_rst));

    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en && tx_ready && !sw_rst) |-> !tx_empty);

    a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !tx_int_en |-> !tx_irq);

    a_r5_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
        !tx_ready |-> !tx_irq);

    a_r6_empty_line_high: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);

    a_r9_full_not_empty: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (fifo_ovf && !sw_rst) |=> fifo_ovf);

endmodule

bind uart_tx_paced uart_tx_paced_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_rst     (sw_rst),
    .tx_int_en  (tx_int_en),
    .bit_tick   (bit_tick),
    .wr_en      (wr_en),
    .ld_fire    (ld_fire),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty),
    .tx_irq     (tx_irq),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .fifo_ovf   (fifo_ovf)
);

// File: tb/test_uart_tx_paced.sv
module test_uart_tx_paced;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int NVEC       = 6;
    // {mode, gap_len, first char, second char, expected idle periods}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 8'd5, 8'hA5, 8'h3C, 8'd0},
        {1'b1, 8'd0, 8'h01, 8'h80, 8'd0},
        {1'b1, 8'd3, 8'hFF, 8'h00, 8'd3},
        {1'b1, 8'd1, 8'h5A, 8'hC3, 8'd1},
        {1'b0, 8'd0, 8'h00, 8'hFF, 8'd0},
        {1'b1, 8'd7, 8'h96, 8'h69, 8'd7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       tx_int_en = 1'b1;
    logic [7:0] gap_len = '0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd, tx_ready, tx_empty, tx_irq, fifo_full, fifo_empty, fifo_ovf;

    int n_checks = 0;
    int n_errors = 0;

    // decoded line
    int       frames[$];
    int       gaps[$];
    int       stop_err = 0;
    int       mon_phase = 0;
    int       idle_cnt = 0;
    int       last_gap = 0;
    int       nbits = 0;
    logic [7:0] acc = '0;
    int       div = 0;

    uart_tx_paced i_uart_tx_paced (
        .clk        (clk),
        .rst        (rst),
        .sw_rst     (sw_rst),
        .fifo_mode  (fifo_mode),
        .tx_int_en  (tx_int_en),
        .gap_len    (gap_len),
        .bit_tick   (bit_tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .txd        (txd),
        .tx_ready   (tx_ready),
        .tx_empty   (tx_empty),
        .tx_irq     (tx_irq),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_ovf   (fifo_ovf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Bit tick source and line decoder; txd is read just before the edge that consumes the tick
    always @(negedge clk) begin
        div = (div + 1) % TICK_DIV;
        bit_tick = (div == 0);
        if (rst || sw_rst) begin
            mon_phase = 0;
            idle_cnt  = 0;
        end else if (bit_tick) begin
            case (mon_phase)
                0: begin
                    if (txd == 1'b0) begin
                        last_gap  = idle_cnt;
                        nbits     = 0;
                        mon_phase = 1;
                    end else begin
                        idle_cnt++;
                    end
                end
                1: begin
                    acc[nbits] = txd;
                    nbits++;
                    if (nbits == 8) mon_phase = 2;
                end
                default: begin
                    frames.push_back(int'(acc));
                    gaps.push_back(last_gap);
                    if (txd !== 1'b1) stop_err++;
                    idle_cnt  = 0;
                    mon_phase = 0;
                end
            endcase
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic soft_reset();
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        frames.delete();
        gaps.delete();
        stop_err = 0;
    endtask

    task automatic wait_frames(input int n);
        int t = 0;
        while (frames.size() < n && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state (R1, R5)
        chk(txd == 1'b1, "R1 txd", int'(txd), 1);
        chk(tx_ready == 1'b1, "R1 ready", int'(tx_ready), 1);
        chk(tx_empty == 1'b1, "R1 empty", int'(tx_empty), 1);
        chk(fifo_empty && !fifo_full && !fifo_ovf, "R1 fifo flags",
            int'({fifo_empty, fifo_full, fifo_ovf}), 3'b100);
        chk(tx_irq == 1'b1, "R5 irq when ready", int'(tx_irq), 1);

        // Vector table: two characters per entry (R2, R3, R7, R8)
        for (int v = 0; v < NVEC; v++) begin
            logic        m;
            logic [7:0]  g, b0, b1, eg;
            {m, g, b0, b1, eg} = VEC[v];
            fifo_mode = m;
            gap_len   = g;
            soft_reset();
            write_char(b0);
            while (!tx_ready) @(negedge clk);
            write_char(b1);
            wait_frames(2);
            chk(frames.size() == 2, "R2 frame count", frames.size(), 2);
            if (frames.size() == 2) begin
                chk(frames[0] == int'(b0), "R2 first char", frames[0], int'(b0));
                chk(frames[1] == int'(b1), "R2 second char", frames[1], int'(b1));
                chk(gaps[1] == int'(eg), m ? "R8 gap" : "R3 back to back", gaps[1], int'(eg));
            end
            chk(stop_err == 0, "R2 stop bit", stop_err, 0);
        end

        // Buffered handoff and ignored write (R3, R4, R5, R6)
        fifo_mode = 1'b0;
        soft_reset();
        write_char(8'h4E);
        chk(tx_ready == 1'b0, "R3 ready low after write", int'(tx_ready), 0);
        chk(tx_irq == 1'b0, "R5 irq low when not ready", int'(tx_irq), 0);
        chk(tx_empty == 1'b0, "R6 empty low", int'(tx_empty), 0);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R3 ready back after move", int'(tx_ready), 1);
        chk(tx_empty == 1'b0, "R6 empty low while shifting", int'(tx_empty), 0);
        write_char(8'hB1);
        chk(tx_ready == 1'b0, "R3 ready low slot held", int'(tx_ready), 0);
        write_char(8'h22);
        wait_frames(2);
        repeat (TICK_DIV * 30) @(negedge clk);
        chk(frames.size() == 2, "R4 ignored write count", frames.size(), 2);
        if (frames.size() == 2)
            chk(frames[1] == 8'hB1, "R4 held char kept", frames[1], 8'hB1);
        chk(tx_empty == 1'b1, "R6 empty after drain", int'(tx_empty), 1);

        // Interrupt enable (R5)
        tx_int_en = 1'b0;
        @(negedge clk);
        chk(tx_irq == 1'b0, "R5 irq masked", int'(tx_irq), 0);
        tx_int_en = 1'b1;

        // Queue fill with push and pop in one cycle (R7, R9, R10)
        fifo_mode = 1'b1;
        gap_len   = 8'd2;
        soft_reset();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 4) chk(fifo_full == 1'b0, "R10 push during pop kept count", int'(fifo_full), 0);
            if (i == 5) begin
                chk(fifo_full == 1'b1, "R9 full after five writes", int'(fifo_full), 1);
                chk(fifo_ovf == 1'b0, "R9 no overflow yet", int'(fifo_ovf), 0);
                chk(tx_ready == 1'b0, "R7 ready follows full", int'(tx_ready), 0);
            end
            wr_en   = 1'b1;
            wr_data = 8'h10 + 8'(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(fifo_ovf == 1'b1, "R9 overflow set", int'(fifo_ovf), 1);
        wait_frames(5);
        repeat (TICK_DIV * 30) @(negedge clk);
        chk(frames.size() == 5, "R9 dropped char", frames.size(), 5);
        for (int k = 0; k < 5 && k < frames.size(); k++) begin
            chk(frames[k] == 16 + k, "R10 queue order", frames[k], 16 + k);
            if (k > 0) chk(gaps[k] == 2, "R8 gap in burst", gaps[k], 2);
        end
        chk(fifo_ovf == 1'b1, "R9 overflow sticky", int'(fifo_ovf), 1);

        // Software reset mid-frame (R11)
        fifo_mode = 1'b0;
        frames.delete();
        write_char(8'h00);
        repeat (TICK_DIV * 3) @(negedge clk);
        chk(txd == 1'b0, "R11 frame in progress", int'(txd), 0);
        @(negedge clk);
        sw_rst  = 1'b1;
        wr_en   = 1'b1;
        wr_data = 8'h77;
        @(negedge clk);
        sw_rst = 1'b0;
        wr_en  = 1'b0;
        chk(txd == 1'b1, "R11 line idle", int'(txd), 1);
        chk(tx_ready && tx_empty, "R11 ready and empty", int'({tx_ready, tx_empty}), 3);
        chk(fifo_ovf == 1'b0, "R11 overflow cleared", int'(fifo_ovf), 0);
        repeat (TICK_DIV * 30) @(negedge clk);
        chk(frames.size() == 0, "R11 nothing sent after", frames.size(), 0);

        summary();
    end

endmodule